// File: doc/BRIEF.md
# Write-Leveling Phase Sweep Engine

This block carries out the fine phase step of DRAM write leveling for every byte lane of one rank at once. After a start request it first waits out the DQS toggle burst. It then steps a DQS transmit phase across a fixed window, one step per accepted feedback sample. It sorts each step, for each lane, into pass or fail using a training feedback count.

Each lane keeps track of its pass runs. The window is treated as circular, so a run that reaches the last step joins a run that began at the first step. The longest run is then checked against a lower and an upper width limit. On x16 devices the start of each odd lane is pulled to within one clock cycle of its even partner. An optional one-cycle offset is added for the low-power variant.

When the sweep completes, a one-cycle done pulse is issued together with a per-lane fail bitmap. The per-lane DQS and DQ delays are updated only when every lane passed.

Top module: `wl_phase_sweep`

## Requirements
- R1: While `ready` is high, each cycle with `sample_valid` high consumes one step. `sweep_phase` starts at 192 and rises by 2 per consumed step. The last step is 318, so one sweep has 64 steps.
- R2: After `start`, `ready` stays low for W clock cycles. W = ceil(QCLK_PS*1024/1e6) * CLK_PER_US, and the 1024 becomes 2048 when `long_mode` is high at start.
- R3: A step passes for a lane when the low 9 bits of that lane's feedback field are 16 or more. Higher bits have no effect.
- R4: A region's width is its number of consecutive passing steps times 2 ticks. The largest region is chosen, and on equal widths the region found first in sweep order wins.
- R5: A pass run still open at the last step is merged with a run that began at the first step. The merged region starts where the later run starts. A lane that passes every step forms one unmerged region of width 128.
- R6: A lane fails when its largest width is 32 or less, or 96 or more. A lane with no passing step has width 0 and fails.
- R7: A lane's DQS delay is its region start tick, plus 64 when `lowpower_mode` was high at start. Its DQ delay is the DQS delay plus 32.
- R8: With `x16_mode` set, an odd lane's start is lowered by 128 if it lies more than 64 above the even partner's start. It is raised by 128 if it lies more than 64 below. This happens before the R7 offset.
- R9: `done` is high for exactly one cycle after the sweep completes, with `fail_mask` valid. If any lane fails, every DQS and DQ delay keeps its previous value.
- R10: After reset, `ready` and `done` are low, and `fail_mask` and all delays are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sweep (accepted when idle) |
| long_mode | input | 1 | Double-length DQS burst wait |
| x16_mode | input | 1 | Align odd lanes to even partners |
| lowpower_mode | input | 1 | Add one qclk to DQS delays |
| sample_valid | input | 1 | Feedback for the current step is present |
| feedback | input | LANES*FB_W (128) | Per-lane feedback counts, lane 0 in the low field |
| ready | output | 1 | Sweep accepting samples |
| sweep_phase | output | DLY_W (10) | DQS phase of the current step |
| done | output | 1 | One-cycle completion pulse |
| fail_mask | output | LANES (8) | Per-lane failure bits |
| dqs_dly | output | LANES*DLY_W (80) | Per-lane DQS delay |
| dq_dly | output | LANES*DLY_W (80) | Per-lane DQ delay |

## Verification
The bench builds the block with LANES=4, FB_W=12, QCLK_PS=1000 and CLK_PER_US=4. This gives waits of 8 and 12 cycles that can be measured exactly, and two x16 lane pairs in which both alignment directions occur at once. Every run drives the full 64-step window, so the bench can place regions anywhere: touching both ends, tied, or sitting exactly on the 32/34 and 94/96 width limits. Feedback values cycle through codes on both sides of the threshold, some with upper bits set.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_SWEEP,
    S_FINAL,
    S_RESOLVE
  } wl_state_t;
endpackage

// File: rtl/wl_wait_timer.sv
module wl_wait_timer #(
  parameter int SHORT_CYC = 8,
  parameter int LONG_CYC  = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic long_sel,
  output logic expired
);
  localparam int CNT_W = $clog2(LONG_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic             run;

  assign expired = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= long_sel ? CNT_W'(LONG_CYC - 1) : CNT_W'(SHORT_CYC - 1);
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  p_expire_once_r2: assert property (@(posedge clk) disable iff (rst)
    expired |=> !expired);
endmodule

// File: rtl/wl_lane_tracker.sv
module wl_lane_tracker #(
  parameter int NSTEPS = 64,
  parameter int IDX_W  = 6,
  parameter int LEN_W  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             sample_en,
  input  logic             pass,
  input  logic [IDX_W-1:0] step,
  input  logic             finalize,
  output logic [IDX_W-1:0] best_start,
  output logic [LEN_W-1:0] best_len
);
  logic             in_run;
  logic [IDX_W-1:0] cur_start;
  logic [LEN_W-1:0] cur_len;
  logic [LEN_W-1:0] head_len;
  logic [LEN_W-1:0] tail_len;

  // wrap merge: an open tail joins the head run unless it is the head run
  assign tail_len = (cur_start != '0) ? (cur_len + head_len) : cur_len;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      in_run     <= 1'b0;
      cur_start  <= '0;
      cur_len    <= '0;
      head_len   <= '0;
      best_start <= '0;
      best_len   <= '0;
    end else if (sample_en) begin
      if (pass) begin
        if (in_run) begin
          cur_len <= cur_len + 1'b1;
        end else begin
          in_run    <= 1'b1;
          cur_start <= step;
          cur_len   <= LEN_W'(1);
        end
      end else if (in_run) begin
        in_run <= 1'b0;
        if (cur_start == '0) head_len <= cur_len;
        if (cur_len > best_len) begin
          best_start <= cur_start;
          best_len   <= cur_len;
        end
      end
    end else if (finalize && in_run) begin
      in_run <= 1'b0;
      if (tail_len > best_len) begin
        best_start <= cur_start;
        best_len   <= tail_len;
      end
    end
  end

  p_len_bound_r4: assert property (@(posedge clk) disable iff (rst)
    best_len <= LEN_W'(NSTEPS));
  p_best_grows_r4: assert property (@(posedge clk) disable iff (rst)
    (!clear && !$past(clear)) |-> best_len >= $past(best_len));
endmodule

// File: rtl/wl_pair_align.sv
module wl_pair_align #(
  parameter int DLY_W = 10,
  parameter int ALIGN = 64,
  parameter int WRAP  = 128
) (
  input  logic             enable,
  input  logic [DLY_W-1:0] odd_start,
  input  logic [DLY_W-1:0] even_start,
  output logic [DLY_W-1:0] aligned
);
  int diff;

  always_comb begin
    diff    = int'(odd_start) - int'(even_start);
    aligned = odd_start;
    if (enable && diff > ALIGN)       aligned = DLY_W'(int'(odd_start) - WRAP);
    else if (enable && diff < -ALIGN) aligned = DLY_W'(int'(odd_start) + WRAP);
  end
endmodule

// File: rtl/wl_phase_sweep.sv
module wl_phase_sweep
  import wl_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int FB_W       = 16,
  parameter int DLY_W      = 10,
  parameter int START      = 192,
  parameter int STOP       = 320,
  parameter int STEP       = 2,
  parameter int QCLK_TICKS = 64,
  parameter int CNT_BITS   = 9,
  parameter int PASS_MIN   = 16,
  parameter int BURST_QCLK = 1024,
  parameter int QCLK_PS    = 1250,
  parameter int CLK_PER_US = 100
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   long_mode,
  input  logic                   x16_mode,
  input  logic                   lowpower_mode,
  input  logic                   sample_valid,
  input  logic [LANES*FB_W-1:0]  feedback,
  output logic                   ready,
  output logic [DLY_W-1:0]       sweep_phase,
  output logic                   done,
  output logic [LANES-1:0]       fail_mask,
  output logic [LANES*DLY_W-1:0] dqs_dly,
  output logic [LANES*DLY_W-1:0] dq_dly
);
  localparam int NSTEPS     = (STOP - START) / STEP;
  localparam int IDX_W      = $clog2(NSTEPS);
  localparam int LEN_W      = IDX_W + 1;
  localparam int LAST_PHASE = START + (NSTEPS - 1) * STEP;
  localparam int MIN_W      = QCLK_TICKS / 2;
  localparam int MAX_W      = (QCLK_TICKS * 3) / 2;
  localparam int DQ_OFF     = QCLK_TICKS / 2;
  localparam int SHORT_US   = (QCLK_PS * BURST_QCLK + 999999) / 1000000;
  localparam int LONG_US    = (QCLK_PS * BURST_QCLK * 2 + 999999) / 1000000;
  localparam int SHORT_CYC  = SHORT_US * CLK_PER_US;
  localparam int LONG_CYC   = LONG_US * CLK_PER_US;

  wl_state_t        state;
  logic [IDX_W-1:0] step;
  logic             lp_q, x16_q;
  logic             tmr_expired;
  logic             sample_en;

  logic [DLY_W-1:0] start_tick [LANES];
  logic [DLY_W-1:0] adj_tick   [LANES];
  logic [DLY_W-1:0] dqs_next   [LANES];
  logic [LANES-1:0] lane_fail;

  assign ready       = (state == S_SWEEP);
  assign sample_en   = ready && sample_valid;
  assign sweep_phase = DLY_W'(START) + DLY_W'(step) * DLY_W'(STEP);

  wl_wait_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (state == S_IDLE && start),
    .long_sel(long_mode),
    .expired (tmr_expired)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [FB_W-1:0]  fb_low;
    logic [IDX_W-1:0] b_start;
    logic [LEN_W-1:0] b_len;
    logic [DLY_W-1:0] width_ticks;

    assign fb_low = feedback[g*FB_W +: FB_W] & FB_W'((1 << CNT_BITS) - 1);

    wl_lane_tracker #(.NSTEPS(NSTEPS), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_trk (
      .clk       (clk),
      .rst       (rst),
      .clear     (state == S_IDLE && start),
      .sample_en (sample_en),
      .pass      (fb_low >= FB_W'(PASS_MIN)),
      .step      (step),
      .finalize  (state == S_FINAL),
      .best_start(b_start),
      .best_len  (b_len)
    );

    assign start_tick[g] = DLY_W'(START) + DLY_W'(b_start) * DLY_W'(STEP);
    assign width_ticks   = DLY_W'(b_len) * DLY_W'(STEP);
    assign lane_fail[g]  = (width_ticks <= DLY_W'(MIN_W)) || (width_ticks >= DLY_W'(MAX_W));

    if (g % 2 == 1) begin : g_odd
      wl_pair_align #(.DLY_W(DLY_W), .ALIGN(QCLK_TICKS), .WRAP(2 * QCLK_TICKS)) u_align (
        .enable    (x16_q),
        .odd_start (start_tick[g]),
        .even_start(start_tick[g-1]),
        .aligned   (adj_tick[g])
      );
    end else begin : g_even
      assign adj_tick[g] = start_tick[g];
    end

    assign dqs_next[g] = adj_tick[g] + (lp_q ? DLY_W'(QCLK_TICKS) : '0);

    p_dq_offset_r7: assert property (@(posedge clk) disable iff (rst)
      (done && fail_mask == '0) |->
        dq_dly[g*DLY_W +: DLY_W] == dqs_dly[g*DLY_W +: DLY_W] + DLY_W'(DQ_OFF));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      step      <= '0;
      lp_q      <= 1'b0;
      x16_q     <= 1'b0;
      done      <= 1'b0;
      fail_mask <= '0;
      dqs_dly   <= '0;
      dq_dly    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          state <= S_WAIT;
          step  <= '0;
          lp_q  <= lowpower_mode;
          x16_q <= x16_mode;
        end
        S_WAIT: if (tmr_expired) state <= S_SWEEP;
        S_SWEEP: if (sample_valid) begin
          if (step == IDX_W'(NSTEPS - 1)) state <= S_FINAL;
          else                            step  <= step + 1'b1;
        end
        S_FINAL: state <= S_RESOLVE;
        S_RESOLVE: begin
          state     <= S_IDLE;
          done      <= 1'b1;
          fail_mask <= lane_fail;
          if (lane_fail == '0) begin
            for (int l = 0; l < LANES; l++) begin
              dqs_dly[l*DLY_W +: DLY_W] <= dqs_next[l];
              dq_dly[l*DLY_W +: DLY_W]  <= dqs_next[l] + DLY_W'(DQ_OFF);
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_phase_step_r1: assert property (@(posedge clk) disable iff (rst)
    (ready && sample_valid && sweep_phase != DLY_W'(LAST_PHASE)) |=>
      sweep_phase == $past(sweep_phase) + DLY_W'(STEP));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_fail_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (done && fail_mask != '0) |-> ($stable(dqs_dly) && $stable(dq_dly)));
endmodule

// File: tb/sim_wl_phase_sweep.sv
`timescale 1ns/1ps
module sim_wl_phase_sweep;
  localparam int LANES = 4;
  localparam int FB_W  = 12;
  localparam int DLY_W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, long_mode = 1'b0, x16_mode = 1'b0, lowpower_mode = 1'b0;
  logic sample_valid = 1'b0;
  logic [LANES*FB_W-1:0]  feedback = '0;
  logic                   ready, done;
  logic [DLY_W-1:0]       sweep_phase;
  logic [LANES-1:0]       fail_mask;
  logic [LANES*DLY_W-1:0] dqs_dly, dq_dly;

  always #10 clk = ~clk;

  wl_phase_sweep #(.LANES(LANES), .FB_W(FB_W), .DLY_W(DLY_W),
                   .QCLK_PS(1000), .CLK_PER_US(4)) u0 (
    .clk(clk), .rst(rst), .start(start), .long_mode(long_mode),
    .x16_mode(x16_mode), .lowpower_mode(lowpower_mode),
    .sample_valid(sample_valid), .feedback(feedback), .ready(ready),
    .sweep_phase(sweep_phase), .done(done), .fail_mask(fail_mask),
    .dqs_dly(dqs_dly), .dq_dly(dq_dly));

  int total = 0, failed = 0;
  logic [63:0] m [LANES];
  int exp_dqs [LANES];
  int exp_dq  [LANES];

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rng(input int a, input int b);
    logic [63:0] v = '0;
    for (int i = a; i <= b; i++) v[i] = 1'b1;
    return v;
  endfunction

  function automatic logic [FB_W-1:0] fb_code(input logic p, input int k);
    case (k % 4)
      0: return p ? 12'h010 : 12'h00F;
      1: return p ? 12'h1FF : 12'h000;
      2: return p ? 12'hE10 : 12'hE0F;
      default: return p ? 12'h0A0 : 12'h200;
    endcase
  endfunction

  // Largest circular region per R4/R5: returns start index and step count
  task automatic model(input logic [63:0] v, output int bs, output int bl);
    int s = -1, head = 0, len;
    bs = 0; bl = 0;
    for (int i = 0; i < 64; i++) begin
      if (v[i]) begin
        if (s < 0) s = i;
      end else if (s >= 0) begin
        len = i - s;
        if (s == 0) head = len;
        if (len > bl) begin bl = len; bs = s; end
        s = -1;
      end
    end
    if (s >= 0) begin
      len = 64 - s;
      if (s != 0) len += head;
      if (len > bl) begin bl = len; bs = s; end
    end
  endtask

  task automatic run(input string tag, input logic lp, input logic x16, input logic lng);
    int n, bs, bl, phase_bad;
    int st [LANES];
    int w  [LANES];
    logic [LANES-1:0] ef;
    @(negedge clk);
    start = 1'b1; lowpower_mode = lp; x16_mode = x16; long_mode = lng;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!ready && n < 100) begin n++; @(negedge clk); end
    chk({tag, " R2 wait"}, n, lng ? 12 : 8);
    phase_bad = 0;
    for (int i = 0; i < 64; i++) begin
      if (i % 7 == 3) begin
        sample_valid = 1'b0;
        @(negedge clk);
      end
      if (!ready || sweep_phase != DLY_W'(192 + 2 * i)) phase_bad++;
      sample_valid = 1'b1;
      for (int l = 0; l < LANES; l++) feedback[l*FB_W +: FB_W] = fb_code(m[l][i], i + l);
      @(negedge clk);
    end
    sample_valid = 1'b0;
    chk({tag, " R1 phase sequence"}, phase_bad, 0);
    n = 0;
    while (!done && n < 20) begin n++; @(negedge clk); end
    chk({tag, " R9 done seen"}, int'(done), 1);
    for (int l = 0; l < LANES; l++) begin
      model(m[l], bs, bl);
      st[l] = 192 + 2 * bs;
      w[l]  = 2 * bl;
      ef[l] = (w[l] <= 32) || (w[l] >= 96);
    end
    if (x16)
      for (int l = 1; l < LANES; l += 2) begin
        if (st[l] > st[l-1] + 64) st[l] -= 128;
        else if (st[l] < st[l-1] - 64) st[l] += 128;
      end
    chk({tag, " R6 fail mask"}, int'(fail_mask), int'(ef));
    if (ef == '0)
      for (int l = 0; l < LANES; l++) begin
        exp_dqs[l] = st[l] + (lp ? 64 : 0);
        exp_dq[l]  = exp_dqs[l] + 32;
      end
    for (int l = 0; l < LANES; l++) begin
      chk({tag, " R3 R4 R5 R7 R8 dqs"}, int'(dqs_dly[l*DLY_W +: DLY_W]), exp_dqs[l]);
      chk({tag, " R7 R9 dq"}, int'(dq_dly[l*DLY_W +: DLY_W]), exp_dq[l]);
    end
    @(negedge clk);
    chk({tag, " R9 done one cycle"}, int'(done), 0);
  endtask

  logic finished = 1'b0;

  initial begin
    #(20 * 150000);
    if (!finished) begin
      failed++; total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < LANES; l++) begin exp_dqs[l] = 0; exp_dq[l] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 ready", int'(ready), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 fail_mask", int'(fail_mask), 0);
    chk("R10 dqs", int'(dqs_dly), 0);
    chk("R10 dq", int'(dq_dly), 0);

    m[0] = rng(5, 24); m[1] = rng(10, 39); m[2] = rng(0, 2) | rng(40, 59); m[3] = rng(20, 44);
    run("basic", 1'b0, 1'b0, 1'b0);

    m[0] = rng(0, 9) | rng(55, 63); m[1] = rng(0, 19) | rng(60, 63);
    m[2] = rng(3, 20) | rng(30, 47); m[3] = rng(40, 57);
    run("wrap tie", 1'b0, 1'b0, 1'b1);

    m[0] = rng(0, 19); m[1] = rng(40, 59); m[2] = rng(40, 59); m[3] = rng(0, 17);
    run("x16", 1'b0, 1'b1, 1'b0);
    run("x16 lowpower", 1'b1, 1'b1, 1'b0);

    m[0] = rng(10, 26); m[1] = rng(5, 51); m[2] = rng(30, 54); m[3] = rng(1, 30);
    run("width edges pass", 1'b0, 1'b0, 1'b0);

    m[0] = rng(10, 25); m[1] = rng(5, 52); m[2] = '1; m[3] = '0;
    run("width edges fail", 1'b0, 1'b0, 1'b0);

    m[0] = rng(0, 25); m[1] = rng(20, 45); m[2] = rng(30, 55); m[3] = rng(3, 12);
    run("single lane fail", 1'b1, 1'b0, 1'b0);

    m[0] = rng(50, 63) | rng(0, 5); m[1] = rng(12, 40); m[2] = rng(22, 44); m[3] = rng(33, 60);
    run("recovery", 1'b1, 1'b1, 1'b1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule